// File: doc/BRIEF.md
# Supply Sequencing Interlock Controller

This block decides when the analog supplies of an instrument backplane may be connected, and in which order. Four comparator flags report whether the digital rail, the positive and negative 15 V rails and the high-voltage rail are within range. An operator enable starts the sequence, and a second command releases the high voltage. Every flag and command is first brought into the clock domain through a two-flop synchroniser. The comparator flags also pass through a persistence filter, so a short excursion is ignored.

Once the enable is present and all four supplies are good, the ±15 V pass switch is driven by an 8-bit control value. This value climbs linearly from zero to full scale over about 40 ms. Only after full scale is reached, and only while the high-voltage command is held, is the high-voltage switch closed.

A sustained out-of-range condition on any supply opens every analog switch in the same cycle and latches a fault. The fault clears only when the enable is withdrawn. Withdrawing the enable during normal operation opens the high-voltage switch first and the ±15 V switch one cycle later. A reset output holds a dependent controller in reset whenever the filtered digital-rail flag reports out of range.

Top module: `supply_seq_ctrl`

## Requirements
- R1: After reset, `ramp_level` is 0, `hv_switch_en` is 0, `fault_flag` is 0, `state_code` is 0 and `dep_reset` is 1.
- R2: `dep_reset` is 1 whenever the filtered digital-rail flag is low, and 0 once that flag has been high for the filter window. While it is 1, both switch outputs are 0 from the next cycle on.
- R3: The sequence leaves the idle state only when the enable is present and all four filtered supply flags are high. An enable given while any flag is low leaves `ramp_level` at 0 and `state_code` at 0.
- R4: While ramping, `ramp_level` rises by exactly 1 every STEP cycles and never moves by any other amount except a drop to 0. STEP = floor(floor(CLK_HZ*RAMP_MS/1000) / 2^RAMP_W), with a minimum of 1.
- R5: When `ramp_level` reaches 2^RAMP_W-1, the block moves to the low-voltage-on state (`state_code` 2) and holds full scale. `hv_switch_en` stays 0 unless the high-voltage command is present.
- R6: `hv_switch_en` is 1 only while `ramp_level` is at full scale and the high-voltage command is held (`state_code` 3). A command given during the ramp takes effect only after the ramp completes.
- R7: A supply flag that stays low for the filter window while any switch is on forces `state_code` 4 and `fault_flag` 1. In that same cycle both `ramp_level` and `hv_switch_en` go to 0.
- R8: The fault state persists while the enable is held, even after every supply recovers. Removing the enable returns the block to `state_code` 0.
- R9: A supply flag excursion shorter than the filter window (FILT = floor(CLK_HZ*FILT_US/1e6), minimum 1) has no effect on any output.
- R10: Removing the enable while the high voltage is on drops `hv_switch_en` first. `ramp_level` falls to 0 exactly one cycle later.
- R11: `state_code` encodings: 0 idle, 1 ramping, 2 low voltage on, 3 high voltage on, 4 fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dig_ok_raw | input | 1 | Digital rail in-range comparator (asynchronous) |
| p15_ok_raw | input | 1 | +15 V rail in-range comparator (asynchronous) |
| n15_ok_raw | input | 1 | −15 V rail in-range comparator (asynchronous) |
| hv_ok_raw | input | 1 | High-voltage rail in-range comparator (asynchronous) |
| enable_cmd | input | 1 | Request to connect analog supplies |
| hv_cmd | input | 1 | Request to connect the high voltage |
| ramp_level | output | RAMP_W | ±15 V pass-switch control value |
| hv_switch_en | output | 1 | High-voltage switch closed |
| dep_reset | output | 1 | Reset to the dependent controller, active high |
| fault_flag | output | 1 | Latched supply fault |
| state_code | output | 3 | Sequencer state (R11 encoding) |

## Verification
The bench builds the block with CLK_HZ = 256000, RAMP_MS = 40 and FILT_US = 250. This gives a ramp step of 40 cycles and a filter window of 64 cycles. With these values a full 255-step ramp takes about ten thousand cycles, so several complete power-up sequences, fault entries and shutdown orderings fit in one run. Glitches of random length below the window, and drops well above it, can also be driven on each rail in turn.

// File: rtl/supseq_pkg.sv
package supseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RAMP  = 3'd1,
    ST_LV    = 3'd2,
    ST_HV    = 3'd3,
    ST_FAULT = 3'd4
  } seq_state_t;

  localparam int SUP_DIG = 0;
  localparam int SUP_P15 = 1;
  localparam int SUP_N15 = 2;
  localparam int SUP_HV  = 3;
  localparam int N_SUP   = 4;

  localparam int CMD_EN  = 0;
  localparam int CMD_HV  = 1;
  localparam int N_CMD   = 2;

  // Clock cycles between successive ramp increments.
  function automatic int unsigned ramp_step_cycles(longint clk_hz, int ramp_ms, int width);
    longint total;
    longint step;
    total = (clk_hz * ramp_ms) / 1000;
    step  = total >> width;
    if (step < 1) step = 1;
    return int'(step);
  endfunction

  // Clock cycles a flag must disagree before the filter accepts it.
  function automatic int unsigned filter_cycles(longint clk_hz, int filt_us);
    longint n;
    n = (clk_hz * filt_us) / 1000000;
    if (n < 1) n = 1;
    return int'(n);
  endfunction

endpackage

// File: rtl/supseq_cond.sv
module supseq_cond #(
  parameter int N        = 4,
  parameter int STAGES   = 2,
  parameter int FILT_CYC = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] clean
);

  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], raw[g]};
    end

    if (FILT_CYC <= 1) begin : g_nofilt
      assign clean[g] = sh[STAGES-1];
    end else begin : g_filt
      logic          q;
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q   <= 1'b0;
          cnt <= '0;
        end else if (sh[STAGES-1] == q) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT_CYC - 1)) begin
          q   <= sh[STAGES-1];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      assign clean[g] = q;
    end
  end

endmodule

// File: rtl/supseq_ramp.sv
module supseq_ramp #(
  parameter int W    = 8,
  parameter int STEP = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clear,
  output logic [W-1:0] level,
  output logic         full
);

  localparam int PW = (STEP > 1) ? $clog2(STEP) : 1;

  logic [PW-1:0] pre;

  assign full = (level == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      level <= '0;
    end else if (clear) begin
      pre   <= '0;
      level <= '0;
    end else if (run && !full) begin
      if (pre == PW'(STEP - 1)) begin
        pre   <= '0;
        level <= level + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

endmodule

// File: rtl/supseq_fsm.sv
module supseq_fsm
  import supseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hv_req,
  input  logic             all_ok,
  input  logic             ramp_full,
  output seq_state_t       state
);

  seq_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:   if (en && all_ok)  nxt = ST_RAMP;
      ST_RAMP:  if (!all_ok)       nxt = ST_FAULT;
                else if (!en)      nxt = ST_OFF;
                else if (ramp_full) nxt = ST_LV;
      ST_LV:    if (!all_ok)       nxt = ST_FAULT;
                else if (!en)      nxt = ST_OFF;
                else if (hv_req)   nxt = ST_HV;
      ST_HV:    if (!all_ok)       nxt = ST_FAULT;
                else if (!en || !hv_req) nxt = ST_LV;
      ST_FAULT: if (!en)           nxt = ST_OFF;
      default:                     nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end

endmodule

// File: rtl/supply_seq_ctrl.sv
module supply_seq_ctrl
  import supseq_pkg::*;
#(
  parameter longint CLK_HZ  = 50000000,
  parameter int     RAMP_MS = 40,
  parameter int     FILT_US = 1000,
  parameter int     RAMP_W  = 8,
  parameter int     SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dig_ok_raw,
  input  logic              p15_ok_raw,
  input  logic              n15_ok_raw,
  input  logic              hv_ok_raw,
  input  logic              enable_cmd,
  input  logic              hv_cmd,
  output logic [RAMP_W-1:0] ramp_level,
  output logic              hv_switch_en,
  output logic              dep_reset,
  output logic              fault_flag,
  output logic [2:0]        state_code
);

  localparam int STEP_CYC = ramp_step_cycles(CLK_HZ, RAMP_MS, RAMP_W);
  localparam int FILT_CYC = filter_cycles(CLK_HZ, FILT_US);

  logic [N_SUP-1:0] sup_raw, sup_ok;
  logic [N_CMD-1:0] cmd_raw, cmd_s;
  logic             all_ok_f;
  logic             en_s;
  logic             ramp_running;
  logic             lv_live;
  logic             ramp_full;
  logic [RAMP_W-1:0] ramp_cnt;
  seq_state_t       state;

  always_comb begin
    sup_raw[SUP_DIG] = dig_ok_raw;
    sup_raw[SUP_P15] = p15_ok_raw;
    sup_raw[SUP_N15] = n15_ok_raw;
    sup_raw[SUP_HV]  = hv_ok_raw;
    cmd_raw[CMD_EN]  = enable_cmd;
    cmd_raw[CMD_HV]  = hv_cmd;
  end

  supseq_cond #(.N(N_SUP), .STAGES(SYNC_N), .FILT_CYC(FILT_CYC)) u_sup (
    .clk(clk), .rst_n(rst_n), .raw(sup_raw), .clean(sup_ok)
  );

  supseq_cond #(.N(N_CMD), .STAGES(SYNC_N), .FILT_CYC(1)) u_cmd (
    .clk(clk), .rst_n(rst_n), .raw(cmd_raw), .clean(cmd_s)
  );

  assign all_ok_f = &sup_ok;
  assign en_s     = cmd_s[CMD_EN];

  supseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en_s), .hv_req(cmd_s[CMD_HV]),
    .all_ok(all_ok_f), .ramp_full(ramp_full), .state(state)
  );

  assign ramp_running = (state == ST_RAMP);
  assign lv_live      = (state == ST_RAMP) || (state == ST_LV) || (state == ST_HV);

  supseq_ramp #(.W(RAMP_W), .STEP(STEP_CYC)) u_ramp (
    .clk(clk), .rst_n(rst_n), .run(ramp_running), .clear(!lv_live),
    .level(ramp_cnt), .full(ramp_full)
  );

  assign ramp_level   = lv_live ? ramp_cnt : '0;
  assign hv_switch_en = (state == ST_HV);
  assign dep_reset    = !sup_ok[SUP_DIG];
  assign fault_flag   = (state == ST_FAULT);
  assign state_code   = state;

endmodule

// File: rtl/supseq_checker.sv
module supseq_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] ramp_level,
  input logic         hv_switch_en,
  input logic         dep_reset,
  input logic         fault_flag,
  input logic [2:0]   state_code,
  input logic         all_ok_f,
  input logic         en_s,
  input logic         ramp_running
);

  a_r2_dep_reset_off: assert property (@(posedge clk) disable iff (!rst_n)
    dep_reset |=> (ramp_level == '0 && !hv_switch_en));

  a_r3_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_running) |-> $past(all_ok_f && en_s));

  a_r4_unit_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_level != $past(ramp_level)) |->
      (ramp_level == $past(ramp_level) + 1'b1) || (ramp_level == '0));

  a_r6_hv_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    hv_switch_en |-> (&ramp_level));

  a_r7_fault_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |-> (ramp_level == '0 && !hv_switch_en));

  a_r8_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && en_s) |=> fault_flag);

  a_r10_hv_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hv_switch_en) && !fault_flag) |-> (ramp_level != '0));

  a_r11_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    state_code <= 3'd4);

endmodule

bind supply_seq_ctrl supseq_checker #(.W(RAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ramp_level(ramp_level), .hv_switch_en(hv_switch_en),
  .dep_reset(dep_reset), .fault_flag(fault_flag), .state_code(state_code),
  .all_ok_f(all_ok_f), .en_s(en_s), .ramp_running(ramp_running)
);

// File: tb/supply_seq_ctrl_bench.sv
`timescale 1ns/1ps
module supply_seq_ctrl_bench;

  localparam longint CLK_HZ  = 256000;
  localparam int     RAMP_MS = 40;
  localparam int     FILT_US = 250;
  localparam int     RW      = 8;
  localparam int     FULL    = (1 << RW) - 1;

  function automatic int exp_step();
    int s;
    s = int'(CLK_HZ / 1000) * RAMP_MS / (2 ** RW);
    return (s < 1) ? 1 : s;
  endfunction

  function automatic int exp_filt();
    int f;
    f = int'(CLK_HZ / 1000) * FILT_US / 1000;
    return (f < 1) ? 1 : f;
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sup = 4'b0000;   // bit0 dig, bit1 +15, bit2 -15, bit3 hv
  logic en = 1'b0, hvc = 1'b0;
  logic [RW-1:0] ramp_level;
  logic hv_switch_en, dep_reset, fault_flag;
  logic [2:0] state_code;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  supply_seq_ctrl #(.CLK_HZ(CLK_HZ), .RAMP_MS(RAMP_MS), .FILT_US(FILT_US), .RAMP_W(RW)) u_supply_seq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .dig_ok_raw(sup[0]), .p15_ok_raw(sup[1]), .n15_ok_raw(sup[2]), .hv_ok_raw(sup[3]),
    .enable_cmd(en), .hv_cmd(hvc),
    .ramp_level(ramp_level), .hv_switch_en(hv_switch_en), .dep_reset(dep_reset),
    .fault_flag(fault_flag), .state_code(state_code)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input int code, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (state_code == 3'(code)) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int step, filt, prev, last_t, t, bad_int, bad_inc, bad_hv, first_t, ramp_t0;
    step = exp_step();
    filt = exp_filt();
    void'($urandom(32'd4711));

    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk(ramp_level == 0, "R1", "ramp after reset", ramp_level, 0);
    chk(!hv_switch_en, "R1", "hv after reset", hv_switch_en, 0);
    chk(state_code == 0 && !fault_flag, "R1", "state after reset", state_code, 0);
    chk(dep_reset, "R1", "dep_reset after reset", dep_reset, 1);

    // R2 digital good releases dependent reset; others stay bad
    sup = 4'b0001;
    cyc(filt + 8);
    chk(!dep_reset, "R2", "dep_reset after dig good", dep_reset, 0);

    // R3 enable while hv rail bad keeps idle
    sup = 4'b0111;
    cyc(filt + 8);
    en = 1'b1;
    cyc(3 * filt);
    chk(state_code == 0 && ramp_level == 0, "R3", "idle with hv rail bad", state_code, 0);

    // R4/R6 ramp with hv command raised mid-ramp
    sup = 4'b1111;
    ramp_t0 = 1 + ($urandom % 200);
    prev = 0; last_t = 0; bad_int = 0; bad_inc = 0; bad_hv = 0; first_t = -1;
    for (int c = 0; c < 20 * step * 256; c++) begin
      @(negedge clk);
      t = c;
      if (c == ramp_t0 * step) hvc = 1'b1;
      if (hv_switch_en && ramp_level != RW'(FULL)) bad_hv++;
      if (int'(ramp_level) != prev) begin
        if (int'(ramp_level) != prev + 1) bad_inc++;
        if (prev >= 1 && (t - last_t) != step) bad_int++;
        if (prev == 0) first_t = t;
        prev = ramp_level;
        last_t = t;
      end
      if (prev == FULL) break;
    end
    chk(prev == FULL, "R4", "ramp reaches full scale", prev, FULL);
    chk(bad_inc == 0, "R4", "ramp increments of one", bad_inc, 0);
    chk(bad_int == 0, "R4", "step interval errors", bad_int, 0);
    chk(last_t - first_t == (FULL - 1) * step, "R4", "ramp span cycles", last_t - first_t, (FULL - 1) * step);
    chk(bad_hv == 0, "R6", "hv before full scale", bad_hv, 0);
    cyc(4);
    chk(state_code == 3 && hv_switch_en, "R6", "hv after ramp with cmd", state_code, 3);

    // R10 shutdown order
    en = 1'b0;
    bad_hv = 1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (!hv_switch_en) begin
        chk(ramp_level == RW'(FULL), "R10", "ramp held when hv opens", ramp_level, FULL);
        @(negedge clk);
        chk(ramp_level == 0, "R10", "ramp drops one cycle later", ramp_level, 0);
        bad_hv = 0;
        break;
      end
    end
    chk(bad_hv == 0, "R10", "hv opened on enable removal", bad_hv, 0);
    cyc(4);
    chk(state_code == 0, "R10", "idle after shutdown", state_code, 0);

    // R5 ramp without hv command
    hvc = 1'b0;
    en = 1'b1;
    wait_state(2, 20 * step * 256);
    cyc(20);
    chk(state_code == 2 && ramp_level == RW'(FULL), "R5", "low voltage on", state_code, 2);
    chk(!hv_switch_en, "R5", "hv closed without cmd", hv_switch_en, 0);

    // R9 short glitches on random rails
    for (int k = 0; k < 10; k++) begin
      int b, len;
      b = $urandom % 4;
      len = 1 + ($urandom % (filt - 4));
      sup[b] = 1'b0;
      cyc(len);
      sup[b] = 1'b1;
      cyc(filt + 6);
      chk(state_code == 2 && ramp_level == RW'(FULL) && !fault_flag, "R9", "glitch ignored", state_code, 2);
    end

    // R7 sustained -15 V drop
    sup[2] = 1'b0;
    cyc(filt + 8);
    chk(fault_flag && state_code == 4, "R7", "fault on -15 drop", state_code, 4);
    chk(ramp_level == 0 && !hv_switch_en, "R7", "switches open on fault", ramp_level, 0);
    // R8 latch
    sup[2] = 1'b1;
    cyc(filt + 8);
    chk(state_code == 4, "R8", "fault held after recovery", state_code, 4);
    en = 1'b0;
    cyc(6);
    chk(state_code == 0 && !fault_flag, "R8", "fault cleared by enable removal", state_code, 0);

    // R7 hv rail drop while high voltage on: both open together
    en = 1'b1; hvc = 1'b1;
    wait_state(3, 20 * step * 256);
    cyc(3);
    chk(hv_switch_en, "R6", "hv on second sequence", hv_switch_en, 1);
    sup[3] = 1'b0;
    bad_hv = 1;
    for (int c = 0; c < filt + 20; c++) begin
      @(negedge clk);
      if (!hv_switch_en) begin
        chk(ramp_level == 0 && fault_flag, "R7", "ramp zero with hv on fault", ramp_level, 0);
        bad_hv = 0;
        break;
      end
    end
    chk(bad_hv == 0, "R7", "hv opened on hv rail fault", bad_hv, 0);
    sup[3] = 1'b1;
    en = 1'b0; hvc = 1'b0;
    cyc(filt + 8);

    // R2 digital rail drop raises dependent reset
    sup[0] = 1'b0;
    cyc(filt + 8);
    chk(dep_reset, "R2", "dep_reset on dig drop", dep_reset, 1);
    en = 1'b1;
    cyc(filt);
    chk(state_code == 0 && ramp_level == 0, "R3", "no start with dig bad", state_code, 0);
    sup[0] = 1'b1;
    cyc(filt + 8);
    chk(!dep_reset, "R2", "dep_reset released", dep_reset, 0);
    chk(state_code == 1, "R11", "ramping code", state_code, 1);

    summary();
  end

endmodule